// File: doc/BRIEF.md
# Multi-Coding Integer Adder/Subtractor

This block adds or subtracts two N-bit signed integers that share one of five codings: two's complement, one's complement, diminished-one, signed-magnitude or excess (bias). A 3-bit mode input picks the coding, and a subtract input picks the operation. The result comes back in the same coding, together with an overflow flag and a zero flag. Diminished-one operands and results carry one extra marker bit that flags the value zero, because the N-bit field has no code for zero in that coding.

A single shared binary adder does the work in every mode. Each coding first negates the second operand in its own way when subtracting. The adder's raw sum is then corrected by a mode-selected term: the end-around carry, the inverted carry, or the bias constant. Signed-magnitude instead steers the adder with a magnitude comparison when the signs differ. One register stage holds the result, and a valid bit travels alongside it. The block is meant for modular arithmetic datapaths: its modes give arithmetic modulo 2^N, 2^N−1 and 2^N+1 with no extra logic.

Top module: `mcode_addsub`

## Requirements
- R1: Mode 0 is two's complement. The result code is (a ± b) mod 2^N, and the carry out of the top bit is dropped.
- R2: Mode 1 is one's complement. Subtraction inverts every bit of b. A carry out of the top bit of a+b' is added back into the bit-0 position, so the result code is a+b' when that sum is below 2^N, and a+b'−2^N+1 otherwise.
- R3: In mode 1, both the all-zeros code and the all-ones code are read as zero on input and raise the zero flag on output.
- R4: Mode 2 is diminished-one. With the marker bit clear, a field whose top bit is 0 holds value field+1, and a field whose top bit is 1 holds its two's-complement value. With the marker bit set, the value is 0. The result is (va ± vb) reduced modulo 2^N+1 into [−2^(N−1), 2^(N−1)] and encoded the same way.
- R5: In mode 2, a zero result sets the result marker bit and clears the field. The result marker bit is always 0 in the other modes.
- R6: Mode 3 is signed-magnitude, with the top bit as the sign (1 = negative). Subtraction flips the sign of b. For like signs the magnitudes add modulo 2^(N−1) and keep the sign. For unlike signs the smaller magnitude is taken from the larger one, and the result carries the larger operand's sign.
- R7: In mode 3, the negative-zero code is read as zero on input, and a zero result magnitude always has its sign bit cleared.
- R8: Mode 4 is excess coding with bias 2^(N−1)−1, and value = code − bias. The result code is (a + b − bias) mod 2^N on addition and (a − b + bias) mod 2^N on subtraction.
- R9: The overflow flag is 1 exactly when the true va ± vb lies outside the mode's range. The ranges are: two's complement [−2^(N−1), 2^(N−1)−1]; one's complement and signed-magnitude ±(2^(N−1)−1); diminished-one ±2^(N−1); excess [−(2^(N−1)−1), 2^(N−1)].
- R10: The zero flag is 1 exactly when the result code means zero in its mode. That is: all zeros in mode 0; all zeros or all ones in mode 1; marker set in mode 2; magnitude zero in mode 3; the bias code in mode 4.
- R11: Results, flags and out_valid_o appear one clock edge after a cycle with in_valid_i high. A cycle with in_valid_i low clears out_valid_o on the next edge and leaves the result and flags unchanged.
- R12: While rst_ni is low, out_valid_o, the result, the marker and both flags are 0.
- R13: Mode values 5 to 7 behave exactly as mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operands and mode are valid this cycle |
| mode_i | input | 3 | Coding select (0 two's, 1 one's, 2 diminished-one, 3 signed-magnitude, 4 excess) |
| sub_i | input | 1 | 1 = a − b, 0 = a + b |
| a_i | input | WIDTH | Operand a code |
| a_zero_i | input | 1 | Diminished-one zero marker for a |
| b_i | input | WIDTH | Operand b code |
| b_zero_i | input | 1 | Diminished-one zero marker for b |
| out_valid_o | output | 1 | Result registers hold a new result |
| sum_o | output | WIDTH | Result code |
| sum_zero_o | output | 1 | Diminished-one zero marker for the result |
| ovf_o | output | 1 | True result outside the coding's range |
| zero_o | output | 1 | Result code represents zero |

## Verification
The hardest cases to reach are the ones where a correction fires: a diminished-one sum whose second addition carries out, and so collapses to the zero marker; and a one's-complement sum whose wrapped carry turns negative zero into positive. Others are signed-magnitude pairs with equal magnitudes and unlike signs, and operands that arrive already marked zero. The stimulus sweeps every pair of 4-bit codes, both operations and, in diminished-one mode, every combination of zero markers, so each of these lands many times. The expected codes come from value arithmetic modulo the mode's ring. A separate idle phase checks that the result and flags are held when in_valid_i is low.

// File: rtl/mcode_pkg.sv
package mcode_pkg;

  typedef enum logic [2:0] {
    CM_TWOS   = 3'd0,
    CM_ONES   = 3'd1,
    CM_DMO    = 3'd2,
    CM_SGNMAG = 3'd3,
    CM_EXCESS = 3'd4
  } code_mode_e;

  // Unassigned encodings fall back to two's complement
  function automatic code_mode_e resolve_mode(input logic [2:0] raw);
    case (raw)
      3'd1:    return CM_ONES;
      3'd2:    return CM_DMO;
      3'd3:    return CM_SGNMAG;
      3'd4:    return CM_EXCESS;
      default: return CM_TWOS;
    endcase
  endfunction

endpackage

// File: rtl/mcode_operand_prep.sv
module mcode_operand_prep
  import mcode_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  code_mode_e       mode_i,
  input  logic             sub_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             b_zero_i,
  output logic [WIDTH-1:0] b_o,
  output logic             b_zero_o
);

  logic [WIDTH-1:0] neg_inc;
  logic [WIDTH-1:0] b_inv_adj;

  // Inversion plus a mode constant: +1 two's, 0 one's/dim-one, -1 excess
  always_comb begin
    case (mode_i)
      CM_TWOS:   neg_inc = WIDTH'(1);
      CM_EXCESS: neg_inc = '1;
      default:   neg_inc = '0;
    endcase
  end

  assign b_inv_adj = ~b_i + neg_inc;

  always_comb begin
    b_o      = b_i;
    b_zero_o = b_zero_i;
    if (sub_i) begin
      case (mode_i)
        CM_SGNMAG: b_o = {~b_i[WIDTH-1], b_i[WIDTH-2:0]};
        CM_DMO:    b_o = b_zero_i ? b_i : b_inv_adj;
        default:   b_o = b_inv_adj;
      endcase
    end
  end

endmodule

// File: rtl/mcode_add_core.sv
module mcode_add_core
  import mcode_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  code_mode_e       mode_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic             a_zero_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             b_zero_i,
  output logic [WIDTH-1:0] res_o,
  output logic             res_zero_o
);

  localparam int MAG_W = WIDTH - 1;
  localparam logic [WIDTH-1:0] EXCESS_FIX = WIDTH'((1 << (WIDTH - 1)) + 1);

  // signed-magnitude steering
  logic             sa, sb, same_sign, a_ge;
  logic [MAG_W-1:0] ma, mb, big_mag, small_mag, sm_mag;
  logic             sm_sign;

  assign sa        = a_i[WIDTH-1];
  assign sb        = b_i[WIDTH-1];
  assign ma        = a_i[MAG_W-1:0];
  assign mb        = b_i[MAG_W-1:0];
  assign same_sign = (sa == sb);
  assign a_ge      = (ma >= mb);
  assign big_mag   = a_ge ? ma : mb;
  assign small_mag = a_ge ? mb : ma;

  // shared adder
  logic [WIDTH-1:0] add_x, add_y;
  logic             add_cin;
  logic [WIDTH:0]   main_sum;
  logic             main_cout;

  always_comb begin
    add_x   = a_i;
    add_y   = b_i;
    add_cin = 1'b0;
    if (mode_i == CM_SGNMAG) begin
      if (same_sign) begin
        add_x = {1'b0, ma};
        add_y = {1'b0, mb};
      end else begin
        add_x   = {1'b0, big_mag};
        add_y   = {1'b0, ~small_mag};
        add_cin = 1'b1;
      end
    end
  end

  assign main_sum  = {1'b0, add_x} + {1'b0, add_y} + {{WIDTH{1'b0}}, add_cin};
  assign main_cout = main_sum[WIDTH];

  // mode-dependent correction term
  logic [WIDTH-1:0] corr;
  logic [WIDTH:0]   fix_sum;

  always_comb begin
    case (mode_i)
      CM_ONES:   corr = {{(WIDTH-1){1'b0}}, main_cout};
      CM_DMO:    corr = {{(WIDTH-1){1'b0}}, ~main_cout};
      CM_EXCESS: corr = EXCESS_FIX;
      default:   corr = '0;
    endcase
  end

  assign fix_sum = {1'b0, main_sum[WIDTH-1:0]} + {1'b0, corr};

  assign sm_mag  = main_sum[MAG_W-1:0];
  assign sm_sign = same_sign ? sa : (a_ge ? sa : sb);

  always_comb begin
    res_o      = fix_sum[WIDTH-1:0];
    res_zero_o = 1'b0;
    case (mode_i)
      CM_SGNMAG: res_o = {sm_sign & (|sm_mag), sm_mag};
      CM_DMO: begin
        if (a_zero_i && b_zero_i) begin
          res_o      = '0;
          res_zero_o = 1'b1;
        end else if (a_zero_i) begin
          res_o = b_i;
        end else if (b_zero_i) begin
          res_o = a_i;
        end else if (fix_sum[WIDTH]) begin
          // second pass carried: residue is zero
          res_o      = '0;
          res_zero_o = 1'b1;
        end
      end
      default: ;
    endcase
  end

  // R2: wrapped carry never produces a second carry
  p_eac_single_pass_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == CM_ONES) |-> !fix_sum[WIDTH]);

  // R6: magnitude compare orders the subtraction so it never borrows
  p_sm_order_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == CM_SGNMAG && !same_sign) |-> (main_sum[WIDTH-1] && !main_cout));

endmodule

// File: rtl/mcode_range_check.sv
module mcode_range_check
  import mcode_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  code_mode_e       mode_i,
  input  logic             sub_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic             a_zero_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             b_zero_i,
  input  logic [WIDTH-1:0] res_i,
  input  logic             res_zero_i,
  output logic             ovf_o,
  output logic             zero_o
);

  localparam int VW = WIDTH + 3;
  localparam logic signed [VW-1:0] HALF  = VW'(1 << (WIDTH - 1));
  localparam logic signed [VW-1:0] BIAS  = HALF - VW'(1);
  localparam logic [WIDTH-1:0]     BIAS_CODE = WIDTH'((1 << (WIDTH - 1)) - 1);

  function automatic logic signed [VW-1:0] decode(input code_mode_e m,
                                                  input logic [WIDTH-1:0] c,
                                                  input logic z);
    logic signed [VW-1:0] se, ze, mag;
    se  = VW'($signed(c));
    ze  = $signed({{(VW-WIDTH){1'b0}}, c});
    mag = $signed({{(VW-WIDTH+1){1'b0}}, c[WIDTH-2:0]});
    case (m)
      CM_ONES:   return se + (c[WIDTH-1] ? VW'(1) : VW'(0));
      CM_DMO:    return z ? '0 : (c[WIDTH-1] ? se : se + VW'(1));
      CM_SGNMAG: return c[WIDTH-1] ? -mag : mag;
      CM_EXCESS: return ze - BIAS;
      default:   return se;
    endcase
  endfunction

  logic signed [VW-1:0] va, vb, vt, lo, hi;

  assign va = decode(mode_i, a_i, a_zero_i);
  assign vb = decode(mode_i, b_i, b_zero_i);
  assign vt = sub_i ? (va - vb) : (va + vb);

  always_comb begin
    case (mode_i)
      CM_ONES, CM_SGNMAG: begin lo = -BIAS; hi = BIAS; end
      CM_DMO:             begin lo = -HALF; hi = HALF; end
      CM_EXCESS:          begin lo = -BIAS; hi = HALF; end
      default:            begin lo = -HALF; hi = BIAS; end
    endcase
  end

  assign ovf_o = (vt < lo) || (vt > hi);

  always_comb begin
    case (mode_i)
      CM_ONES:   zero_o = (res_i == '0) || (&res_i);
      CM_DMO:    zero_o = res_zero_i;
      CM_SGNMAG: zero_o = (res_i[WIDTH-2:0] == '0);
      CM_EXCESS: zero_o = (res_i == BIAS_CODE);
      default:   zero_o = (res_i == '0);
    endcase
  end

endmodule

// File: rtl/mcode_addsub.sv
module mcode_addsub
  import mcode_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic [2:0]       mode_i,
  input  logic             sub_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic             a_zero_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             b_zero_i,
  output logic             out_valid_o,
  output logic [WIDTH-1:0] sum_o,
  output logic             sum_zero_o,
  output logic             ovf_o,
  output logic             zero_o
);

  code_mode_e       mode_eff;
  logic [WIDTH-1:0] b_eff, res;
  logic             b_zero_eff, res_zero, ovf, zero;

  assign mode_eff = resolve_mode(mode_i);

  mcode_operand_prep #(.WIDTH(WIDTH)) u_prep (
    .mode_i   (mode_eff),
    .sub_i    (sub_i),
    .b_i      (b_i),
    .b_zero_i (b_zero_i),
    .b_o      (b_eff),
    .b_zero_o (b_zero_eff)
  );

  mcode_add_core #(.WIDTH(WIDTH)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode_eff),
    .a_i        (a_i),
    .a_zero_i   (a_zero_i),
    .b_i        (b_eff),
    .b_zero_i   (b_zero_eff),
    .res_o      (res),
    .res_zero_o (res_zero)
  );

  mcode_range_check #(.WIDTH(WIDTH)) u_range (
    .mode_i     (mode_eff),
    .sub_i      (sub_i),
    .a_i        (a_i),
    .a_zero_i   (a_zero_i),
    .b_i        (b_i),
    .b_zero_i   (b_zero_i),
    .res_i      (res),
    .res_zero_i (res_zero),
    .ovf_o      (ovf),
    .zero_o     (zero)
  );

  code_mode_e mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      sum_o       <= '0;
      sum_zero_o  <= 1'b0;
      ovf_o       <= 1'b0;
      zero_o      <= 1'b0;
      mode_q      <= CM_TWOS;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) begin
        sum_o      <= res;
        sum_zero_o <= res_zero;
        ovf_o      <= ovf;
        zero_o     <= zero;
        mode_q     <= mode_eff;
      end
    end
  end

  p_valid_launch_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);

  p_idle_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> (!out_valid_o && $stable(sum_o) && $stable(ovf_o) && $stable(zero_o)));

  p_sm_no_neg_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && mode_q == CM_SGNMAG && sum_o[WIDTH-1]) |-> (sum_o[WIDTH-2:0] != '0));

  p_dmo_zero_field_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && mode_q == CM_DMO && sum_zero_o) |-> (sum_o == '0 && zero_o));

  p_marker_dmo_only_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && mode_q != CM_DMO) |-> !sum_zero_o);

endmodule

// File: tb/mcode_addsub_bench.sv
`timescale 1ns/1ps
module mcode_addsub_bench;

  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         in_valid = 1'b0;
  logic [2:0]   mode = '0;
  logic         sub = 1'b0;
  logic [W-1:0] a = '0, b = '0;
  logic         az = 1'b0, bz = 1'b0;
  logic         out_valid, sum_zero, ovf, zero;
  logic [W-1:0] sum;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  mcode_addsub #(.WIDTH(W)) u_mcode_addsub (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .mode_i(mode), .sub_i(sub),
    .a_i(a), .a_zero_i(az), .b_i(b), .b_zero_i(bz),
    .out_valid_o(out_valid), .sum_o(sum), .sum_zero_o(sum_zero), .ovf_o(ovf), .zero_o(zero)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (mode %0d sub %0d a %0d/%0d b %0d/%0d)",
               tag, act, exp, mode, sub, a, az, b, bz);
    end
  endtask

  function automatic int dec(input int m, input int c, input int z);
    case (m)
      1: return (c >= 8) ? c - 15 : c;
      2: return z ? 0 : ((c >= 8) ? c - 16 : c + 1);
      3: return (c >= 8) ? -(c - 8) : c;
      4: return c - 7;
      default: return (c >= 8) ? c - 16 : c;
    endcase
  endfunction

  // expected {code, marker, ovf, zero}
  task automatic model(input int m, input int s, input int ca, input int za,
                       input int cb, input int zb,
                       output int e_code, output int e_mark, output int e_ovf, output int e_zero);
    int va, vb, vt, lo, hi, bb, t, r, ma, mb, sa, sb, mg, sg;
    va = dec(m, ca, za);
    vb = dec(m, cb, zb);
    vt = s ? va - vb : va + vb;
    e_mark = 0;
    case (m)
      1: begin
        bb = s ? 15 - cb : cb;
        t  = ca + bb;
        e_code = (t >= 16) ? t - 16 + 1 : t;
        e_zero = (e_code == 0 || e_code == 15) ? 1 : 0;
        lo = -7; hi = 7;
      end
      2: begin
        r = ((vt % 17) + 17) % 17;
        if (r > 8) r -= 17;
        if (r == 0) begin e_code = 0; e_mark = 1; end
        else if (r > 0) e_code = r - 1;
        else e_code = r + 16;
        e_zero = e_mark;
        lo = -8; hi = 8;
      end
      3: begin
        sa = ca / 8; ma = ca % 8;
        sb = (cb / 8) ^ s; mb = cb % 8;
        if (sa == sb) begin mg = (ma + mb) % 8; sg = sa; end
        else if (ma >= mb) begin mg = ma - mb; sg = sa; end
        else begin mg = mb - ma; sg = sb; end
        if (mg == 0) sg = 0;
        e_code = sg * 8 + mg;
        e_zero = (mg == 0) ? 1 : 0;
        lo = -7; hi = 7;
      end
      4: begin
        e_code = s ? ((ca - cb + 7 + 16) % 16) : ((ca + cb - 7 + 16) % 16);
        e_zero = (e_code == 7) ? 1 : 0;
        lo = -7; hi = 8;
      end
      default: begin
        e_code = s ? ((ca - cb + 16) % 16) : ((ca + cb) % 16);
        e_zero = (e_code == 0) ? 1 : 0;
        lo = -8; hi = 7;
      end
    endcase
    e_ovf = (vt < lo || vt > hi) ? 1 : 0;
  endtask

  function automatic string mode_tag(input int m);
    case (m)
      0: return "R1";
      1: return "R2";
      2: return "R4";
      3: return "R6/R7";
      4: return "R8";
      default: return "R13";
    endcase
  endfunction

  // drive at a falling edge, sample at the next falling edge
  task automatic run_op(input int m, input int s, input int ca, input int za,
                        input int cb, input int zb);
    int e_code, e_mark, e_ovf, e_zero;
    mode = 3'(m); sub = s[0]; a = W'(ca); b = W'(cb); az = za[0]; bz = zb[0];
    in_valid = 1'b1;
    model(m, s, ca, za, cb, zb, e_code, e_mark, e_ovf, e_zero);
    @(negedge clk);
    check(mode_tag(m), int'(sum), e_code);
    check("R9 ovf", int'(ovf), e_ovf);
    check((m == 1) ? "R3 zero" : "R10 zero", int'(zero), e_zero);
    check("R5 marker", int'(sum_zero), e_mark);
    check("R11 valid", int'(out_valid), 1);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    int h_sum, h_ovf, h_zero;
    repeat (3) @(negedge clk);
    // R12: reset state
    check("R12 valid", int'(out_valid), 0);
    check("R12 sum", int'(sum), 0);
    check("R12 marker", int'(sum_zero), 0);
    check("R12 ovf", int'(ovf), 0);
    check("R12 zero", int'(zero), 0);
    rst_ni = 1'b1;
    @(negedge clk);

    for (int m = 0; m < 8; m++)
      for (int s = 0; s < 2; s++)
        for (int ca = 0; ca < 16; ca++)
          for (int cb = 0; cb < 16; cb++) begin
            if (m == 2) begin
              for (int zz = 0; zz < 4; zz++) run_op(m, s, ca, zz / 2, cb, zz % 2);
            end else begin
              run_op(m, s, ca, 0, cb, 0);
            end
          end

    // R11: idle cycles hold the last result while inputs change
    run_op(0, 0, 5, 0, 6, 0);
    h_sum = int'(sum); h_ovf = int'(ovf); h_zero = int'(zero);
    in_valid = 1'b0; mode = 3'd3; a = 4'd15; b = 4'd9; sub = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R11 idle valid", int'(out_valid), 0);
      check("R11 idle sum", int'(sum), h_sum);
      check("R11 idle ovf", int'(ovf), h_ovf);
      check("R11 idle zero", int'(zero), h_zero);
    end

    done = 1'b1;
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule